// File: doc/BRIEF.md
# Truncated Carry-Save Tree Multiplier (16-bit)

This block multiplies two 16-bit two's-complement operands in a single combinational pass and returns only the low 16 bits of the product. It has no clock and no state. A change on an input is reflected at the output after the logic settles.

Each bit of the multiplier operand `b` gates one copy of `a`. The copy for bit i is moved left by i places using fixed wiring, so there are sixteen partial-product rows. Fourteen three-input carry-save stages reduce those rows to two vectors. The stages are scheduled first-in first-out, which forms a tree whose outputs feed later stages. A single ripple-carry adder then combines the two vectors.

Every row is cut to 16 bits, and each carry vector moves up one place and drops its top bit. The result is therefore the signed product modulo 2^16. No sign-extension correction row is needed, and the final carry-out is thrown away.

Top module: `trunc_csa_mult`

## Requirements
- R1: The block is purely combinational. It has no clock or reset, and the output follows the inputs with no register in the path.
- R2: For every pair of operands, `p` equals the low 16 bits of the true product of `a` and `b`. This value is the same whether the operands are read as signed or as unsigned.
- R3: If either operand is 0x0000, `p` is 0x0000.
- R4: If `b` is 0x0001, `p` equals `a`. If `a` is 0x0001, `p` equals `b`.
- R5: If `b` is 0xFFFF (-1), `p` is the two's-complement negation of `a` modulo 2^16. For example, 0x8000 times -1 gives 0x8000.
- R6: If `b` has exactly one bit set, at position k, `p` equals `a` moved left by k places with zeros filled in from the bottom.
- R7: Bit 0 of `p` is the AND of bit 0 of `a` and bit 0 of `b`.
- R8: Swapping the two operands does not change `p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 16 | Multiplicand, two's complement |
| b | input | 16 | Multiplier, two's complement; bit i gates partial-product row i |
| p | output | 16 | Low 16 bits of the product a times b |

## Verification
The assertions sample the inputs and output together after the inputs have settled. They assume the operands do not change while the check is evaluated, since a combinational output seen mid-change would be meaningless. The stimulus respects this by changing operands only on one clock edge and sampling one nanosecond later, well after all logic has settled. Random operand pairs come from `$urandom` with a fixed seed and span the full 16-bit range. They are mixed with directed values at zero, one, minus one, the largest positive value, the most negative value and every single-bit pattern.

// File: rtl/trunc_csa_mult.sv
module trunc_csa_mult #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  localparam int NCSA = W - 2;
  localparam int NVEC = W + 2 * NCSA;
  localparam int FX   = NVEC - 2;
  localparam int FY   = NVEC - 1;

  logic [W-1:0] vec [NVEC];

  // partial-product rows: fixed wiring, row i gated by b[i]
  for (genvar i = 0; i < W; i++) begin : g_row
    if (i == 0) begin : g_first
      assign vec[i] = b[i] ? a : '0;
    end else begin : g_rest
      assign vec[i] = b[i] ? {a[W-1-i:0], {i{1'b0}}} : '0;
    end
  end

  // carry-save tree, queue order: stage k eats vec[3k..3k+2], emits vec[W+2k], vec[W+2k+1]
  for (genvar k = 0; k < NCSA; k++) begin : g_csa
    logic [W-1:0] x, y, z, maj;
    assign x   = vec[3*k];
    assign y   = vec[3*k+1];
    assign z   = vec[3*k+2];
    assign maj = (x & y) | (x & z) | (y & z);
    assign vec[W+2*k]   = x ^ y ^ z;
    assign vec[W+2*k+1] = {maj[W-2:0], 1'b0};
  end

  // final ripple-carry adder, carry-out discarded
  logic [W-1:0] fx, fy, cy;
  assign fx    = vec[FX];
  assign fy    = vec[FY];
  assign cy[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_rca
    assign p[j] = fx[j] ^ fy[j] ^ cy[j];
    if (j < W - 1) begin : g_c
      assign cy[j+1] = (fx[j] & fy[j]) | (fx[j] & cy[j]) | (fy[j] & cy[j]);
    end
  end
endmodule

module trunc_csa_mult_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] p
);
  always_comb begin
    if (!$isunknown({a, b, p})) begin
      AST_ZERO_A:   assert (a != '0 || p == '0);                 // R3
      AST_ZERO_B:   assert (b != '0 || p == '0);                 // R3
      AST_UNIT_B:   assert (b != W'(1) || p == a);               // R4
      AST_UNIT_A:   assert (a != W'(1) || p == b);               // R4
      AST_NEG_ONE:  assert (b != '1 || p == W'(~a + W'(1)));     // R5
      AST_LSB:      assert (p[0] == (a[0] & b[0]));              // R7
      AST_ONEHOT_B: assert (!$onehot(b) || (p & (b - W'(1))) == '0); // R6
    end
  end
endmodule

bind trunc_csa_mult trunc_csa_mult_chk #(.W(W)) u_chk (.a(a), .b(b), .p(p));

// File: tb/sim_trunc_csa_mult.sv
module sim_trunc_csa_mult;
  logic clk = 1'b0;
  logic [15:0] a, b;
  logic [15:0] p;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trunc_csa_mult u0 (.a(a), .b(b), .p(p));

  function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] full;
    full = {16'h0, x} * {16'h0, y};
    return full[15:0];
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y);
    @(posedge clk);
    a = x;
    b = y;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, got, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [5];
    logic [15:0] x, y, p1;
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
    corner[3] = 16'h7FFF; corner[4] = 16'h8000;
    void'($urandom(32'd20240229));

    // R1: output follows inputs immediately, no clock involved
    apply(16'd3, 16'd5);
    check("R1", p, 16'd15);
    a = 16'd7; #1;
    check("R1", p, 16'd35);

    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        apply(corner[i], corner[j]);
        check("R2", p, ref_mul(corner[i], corner[j]));
        if (corner[i] == 16'h0 || corner[j] == 16'h0) check("R3", p, 16'h0);
      end
    end

    apply(16'h8000, 16'hFFFF);
    check("R5", p, 16'h8000);
    apply(16'h1234, 16'hFFFF);
    check("R5", p, 16'hEDCC);
    apply(16'hBEEF, 16'h0001);
    check("R4", p, 16'hBEEF);
    apply(16'h0001, 16'hCAFE);
    check("R4", p, 16'hCAFE);
    apply(16'h0000, 16'hA5A5);
    check("R3", p, 16'h0000);
    apply(16'hFFFF, 16'hFFFF);
    check("R2", p, 16'h0001);
    apply(16'h7FFF, 16'h7FFF);
    check("R2", p, 16'h0001);

    for (int k = 0; k < 16; k++) begin
      x = 16'($urandom);
      apply(x, 16'h1 << k);
      check("R6", p, x << k);
    end

    for (int n = 0; n < 3000; n++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      apply(x, y);
      check("R2", p, ref_mul(x, y));
      check("R7", {15'h0, p[0]}, {15'h0, x[0] & y[0]});
      if (n < 300) begin
        p1 = p;
        apply(y, x);
        check("R8", p, p1);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule